// File: doc/BRIEF.md
# Shared-Count Port Debounce Filter

This block cleans up the inputs of one eight-pin port. Each raw pin is first brought into the clock domain by a short synchroniser chain. A pin can then either pass straight through or be debounced. When it is debounced, its filtered output moves to a new level only after the raw input has held that level for a programmed number of millisecond ticks. The tick is a one-cycle pulse generated elsewhere in the system clock domain.

All pins of the port share one 8-bit stable-time register, counted in milliseconds. Every pin has its own enable bit and its own stability timer. The enable bits are written through a masked register, so one write can change chosen pins without a read-modify-write. Each time a pin's raw level changes, the pin latches the current stable time. A new stable time therefore applies to each pin at that pin's next change, and a filter that is already running keeps the limit it started with.

Top module: `port_debounce`

## Requirements
- R1: With reset asserted, the enable bits and the stable-time register are zero. After reset is released, `filt_o` equals `pin_i` as it was two clock edges earlier.
- R2: A pin whose enable bit is 0, or any pin while the stable time is 0, passes through. Its `filt_o` bit equals its `pin_i` bit from two clock edges earlier.
- R3: A write to address 0x30 updates the enable bits through a mask. Bits [15:8] of the write data select the pins to change and bits [7:0] give their new enable values. Unselected enable bits keep their value. A read of 0x30 returns the enable bits in [7:0] and zero in [15:8].
- R4: A write to address 0xF0 sets the 8-bit stable time. Write data above 255 is stored as 255. A read of 0xF0 returns the stable time in [7:0]. Reads of any other address return 0.
- R5: For an enabled pin with a stable time N greater than 0, `filt_o` takes the new raw level on the Nth tick after the change reaches the filter. After N-1 ticks it has not changed. A filtered bit changes only on a cycle that follows a tick.
- R6: A raw pulse shorter than N ticks never reaches `filt_o`. Any change of the raw level restarts the pin's timer from zero.
- R7: A tick in the same cycle as a restart is not counted.
- R8: A pin latches the stable time when it restarts. A later write to the stable time, including one in the restart cycle itself, does not change a filter already in progress and does not change an output already filtered. The new value applies from the pin's next restart.
- R9: Clearing a pin's enable bit makes its `filt_o` show the synchronised raw level from the cycle after the write, even if a filter was in progress.
- R10: Each pin has its own timer, so changes on different pins at different times resolve independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw pin levels |
| tick_i | input | 1 | One-cycle millisecond tick |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address (write and read) |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i |
| filt_o | output | 8 | Filtered pin levels |

## Verification
Three pairs of events can fall in the same clock edge: a tick and a timer restart, a stable-time write and a restart, and a tick and an input change that has just arrived. The bench counts the synchroniser edges so that it can raise the tick, or write a new stable time, in exactly the cycle when the changed level reaches a pin's filter. In the first case it checks that one more tick is still too few and that the tick after it resolves the pin. In the second case it checks that the pin finishes with the old limit and that the next change on that pin waits for the new limit.

// File: rtl/port_dbc_pkg.sv
package port_dbc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] EN_ADDR  = 8'h30;
  localparam logic [ADDR_W-1:0] CNT_ADDR = 8'hF0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EN,
    SEL_CNT
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == EN_ADDR) return SEL_EN;
    if (a == CNT_ADDR) return SEL_CNT;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/port_dbc_sync.sv
module port_dbc_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/port_dbc_regs.sv
module port_dbc_regs
  import port_dbc_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned DATA_W = 2 * NPINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NPINS-1:0]  en_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [NPINS-1:0] en_q;
  logic [CNT_W-1:0] cnt_q;
  reg_sel_e         sel;

  logic [NPINS-1:0] wmask, wval;
  assign wmask = wdata_i[DATA_W-1:NPINS];
  assign wval  = wdata_i[NPINS-1:0];
  assign sel   = decode(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cnt_q <= '0;
    end else if (we_i) begin
      if (sel == SEL_EN) en_q <= (en_q & ~wmask) | (wval & wmask);
      if (sel == SEL_CNT) begin
        // saturate to the largest representable count
        if (|wdata_i[DATA_W-1:CNT_W]) cnt_q <= '1;
        else                          cnt_q <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_EN:  rdata_o[NPINS-1:0] = en_q;
      SEL_CNT: rdata_o[CNT_W-1:0] = cnt_q;
      default: rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/port_dbc_pin.sv
module port_dbc_pin #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             filt_o
);
  logic             last_q, stable_q;
  logic [CNT_W-1:0] timer_q, lim_q;
  logic             restart, pend, done;

  assign restart = raw_i != last_q;
  assign pend    = last_q != stable_q;
  assign done    = ({1'b0, timer_q} + 1'b1) >= {1'b0, lim_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= 1'b0;
      stable_q <= 1'b0;
      timer_q  <= '0;
      lim_q    <= '0;
    end else if (!active_i) begin
      last_q   <= raw_i;
      stable_q <= raw_i;
      timer_q  <= '0;
      lim_q    <= limit_i;
    end else if (restart) begin
      // restart wins over a tick in the same cycle
      last_q  <= raw_i;
      timer_q <= '0;
      lim_q   <= limit_i;
    end else if (pend && tick_i) begin
      if (done) begin
        stable_q <= last_q;
        timer_q  <= '0;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end else if (!pend) begin
      timer_q <= '0;
    end
  end

  assign filt_o = active_i ? stable_q : raw_i;
endmodule

// File: rtl/port_debounce.sv
module port_debounce
  import port_dbc_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = 2 * NPINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NPINS-1:0]  filt_o
);
  logic [NPINS-1:0] sync_w;
  logic [NPINS-1:0] en_w;
  logic [CNT_W-1:0] cnt_w;
  logic             cnt_nz;

  port_dbc_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  port_dbc_regs #(.NPINS(NPINS), .CNT_W(CNT_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .en_o   (en_w),
    .cnt_o  (cnt_w)
  );

  assign cnt_nz = |cnt_w;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    port_dbc_pin #(.CNT_W(CNT_W)) u_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (sync_w[g]),
      .tick_i  (tick_i),
      .active_i(en_w[g] & cnt_nz),
      .limit_i (cnt_w),
      .filt_o  (filt_o[g])
    );
  end
endmodule

// File: rtl/port_debounce_chk.sv
module port_debounce_chk
  import port_dbc_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned DATA_W = 2 * NPINS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPINS-1:0]  pin_i,
  input logic              tick_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [NPINS-1:0]  filt_o,
  input logic [NPINS-1:0]  en_i,
  input logic [CNT_W-1:0]  cnt_i
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  logic en_wr, cnt_wr;
  assign en_wr  = bus_we_i && (bus_addr_i == EN_ADDR);
  assign cnt_wr = bus_we_i && (bus_addr_i == CNT_ADDR);

  p_mask_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> ((en_i ^ $past(en_i)) & ~$past(bus_wdata_i[DATA_W-1:NPINS])) == '0);

  p_en_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr |=> $stable(en_i));

  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && (|bus_wdata_i[DATA_W-1:CNT_W])) |=> (&cnt_i));

  p_cnt_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> $stable(cnt_i));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd3 && (!en_i[g] || cnt_i == '0)) |-> filt_o[g] == $past(pin_i[g], 2));

    p_change_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2 && en_i[g] && cnt_i != '0 && $past(en_i[g]) && $past(cnt_i) != '0
       && filt_o[g] != $past(filt_o[g])) |-> $past(tick_i));
  end
endmodule

bind port_debounce port_debounce_chk #(.NPINS(NPINS), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_i      (pin_i),
  .tick_i     (tick_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .filt_o     (filt_o),
  .en_i       (en_w),
  .cnt_i      (cnt_w)
);

// File: tb/port_debounce_test.sv
`timescale 1ns/100ps
module port_debounce_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pin = 8'h00;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic [7:0]  filt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  port_debounce uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pin_i      (pin),
    .tick_i     (tick),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .filt_o     (filt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #0.5 d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // change one pin and wait until the filter has seen it
  task automatic set_pin(input int b, input logic v);
    @(negedge clk); pin[b] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    pin = 8'hA5;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 filt after reset", {8'h00, filt}, 16'h00A5);
    rd(8'h30, d); check("R1 enable reset", d, 16'h0000);
    rd(8'hF0, d); check("R1 count reset", d, 16'h0000);
    @(negedge clk); pin = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(8'h30, 16'h0501); rd(8'h30, d); check("R3 masked set", d, 16'h0001);
    wr(8'h30, 16'h0404); rd(8'h30, d); check("R3 keep unselected", d, 16'h0005);
    wr(8'h30, 16'h0100); rd(8'h30, d); check("R3 masked clear", d, 16'h0004);
    wr(8'hF0, 16'h1234); rd(8'hF0, d); check("R4 saturate", d, 16'h00FF);
    wr(8'hF0, 16'h0007); rd(8'hF0, d); check("R4 plain value", d, 16'h0007);
    rd(8'h44, d); check("R4 other addr", d, 16'h0000);
    wr(8'h30, 16'hFF00);
  endtask

  task automatic t_bypass();
    wr(8'hF0, 16'h0000);
    wr(8'h30, 16'hFFFF);
    @(negedge clk); pin[6] = 1'b1;
    @(negedge clk); check("R2 count0 latency1", {15'd0, filt[6]}, 16'd0);
    @(negedge clk); check("R2 count0 latency2", {15'd0, filt[6]}, 16'd1);
    wr(8'hF0, 16'h0003);
    wr(8'h30, 16'hFF7F);
    @(negedge clk); pin[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 disabled pin follows", {15'd0, filt[7]}, 16'd1);
    @(negedge clk); pin[7] = 1'b0; pin[6] = 1'b0;
    wr(8'h30, 16'hFF00);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_basic();
    wr(8'hF0, 16'd3);
    wr(8'h30, 16'h0101);
    set_pin(0, 1'b1);
    pulse(2); check("R5 before N ticks", {15'd0, filt[0]}, 16'd0);
    pulse(1); check("R5 at N ticks", {15'd0, filt[0]}, 16'd1);
    set_pin(0, 1'b0);
    pulse(2); check("R5 falling before N", {15'd0, filt[0]}, 16'd1);
    pulse(1); check("R5 falling at N", {15'd0, filt[0]}, 16'd0);
  endtask

  task automatic t_glitch();
    wr(8'hF0, 16'd3);
    wr(8'h30, 16'h2020);
    set_pin(5, 1'b1);
    pulse(2);
    set_pin(5, 1'b0);
    pulse(3); check("R6 short pulse rejected", {15'd0, filt[5]}, 16'd0);
    set_pin(5, 1'b1);
    pulse(2); check("R6 timer restarted", {15'd0, filt[5]}, 16'd0);
    pulse(1); check("R6 full hold accepted", {15'd0, filt[5]}, 16'd1);
  endtask

  task automatic t_tick_collide();
    wr(8'hF0, 16'd2);
    wr(8'h30, 16'h0202);
    @(negedge clk); pin[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); tick = 1'b1;   // lands on the restart edge
    @(negedge clk); tick = 1'b0;
    pulse(1); check("R7 restart tick not counted", {15'd0, filt[1]}, 16'd0);
    pulse(1); check("R7 resolves on next tick", {15'd0, filt[1]}, 16'd1);
  endtask

  task automatic t_cnt_collide();
    logic [15:0] d;
    wr(8'hF0, 16'd2);
    wr(8'h30, 16'h0404);
    @(negedge clk); pin[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 8'hF0; wdata = 16'd5;
    @(negedge clk); we = 1'b0;
    rd(8'hF0, d); check("R8 count written", d, 16'd5);
    pulse(2); check("R8 old limit kept", {15'd0, filt[2]}, 16'd1);
    wr(8'hF0, 16'd9);
    check("R8 filtered output kept", {15'd0, filt[2]}, 16'd1);
    wr(8'hF0, 16'd5);
    set_pin(2, 1'b0);
    pulse(4); check("R8 new limit pending", {15'd0, filt[2]}, 16'd1);
    pulse(1); check("R8 new limit reached", {15'd0, filt[2]}, 16'd0);
  endtask

  task automatic t_disable();
    wr(8'hF0, 16'd4);
    wr(8'h30, 16'h0808);
    set_pin(3, 1'b1);
    pulse(1); check("R9 pending before disable", {15'd0, filt[3]}, 16'd0);
    @(negedge clk); we = 1'b1; addr = 8'h30; wdata = 16'h0800;
    @(negedge clk); we = 1'b0;
    check("R9 passes after disable", {15'd0, filt[3]}, 16'd1);
  endtask

  task automatic t_indep();
    wr(8'hF0, 16'd3);
    wr(8'h30, 16'h1818);
    set_pin(3, 1'b0);
    set_pin(3, 1'b1);
    pulse(1);
    set_pin(4, 1'b1);
    pulse(2);
    check("R10 pin3 resolved", {15'd0, filt[3]}, 16'd1);
    check("R10 pin4 pending", {15'd0, filt[4]}, 16'd0);
    pulse(1);
    check("R10 pin4 resolved", {15'd0, filt[4]}, 16'd1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_bypass();
    t_basic();
    t_glitch();
    t_tick_collide();
    t_cnt_collide();
    t_disable();
    t_indep();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule